// File: doc/BRIEF.md
# Two-Half Word Read Buffer

This block sits between a serial word receiver and a 16-bit host bus. Each time the receiver presents a complete word with a one-cycle write strobe, the block stores it and raises a ready flag. The host then fetches the word as two halves by pulsing an active-low read strobe twice. The first pulse presents the lower half. The second pulse presents the upper half.

The read strobe is asynchronous to the block clock. It passes through a synchronizer before any logic uses it. The output data bus stands in for a tri-state bus: an output-enable signal is high only while the synchronized strobe is low, and the data lines are held at zero whenever the enable is low.

A half pointer selects which half the next read presents. The pointer moves on the synchronized rising edge of the strobe, after the half has been shown on the bus. The ready flag drops when the lower-half read completes. A newly written word always replaces the stored word and sends the pointer back to the lower half, even if the previous word has not been read.

Top module: `half_word_read_buffer`

## Requirements
- R1: While reset is held, and after it is released, `word_ready` is 0, `half_sel` is 0 and `dout_oe` is 0. The stored word is zero, so a read taken straight after reset returns 0 for both halves.
- R2: A clock edge that samples `wr_stb` high stores `wr_word`. From that edge on, `word_ready` is 1 and `half_sel` is 0.
- R3: A read taken while `half_sel` is 0 presents stored bits [HALF_W-1:0] on `dout`. A read taken while `half_sel` is 1 presents stored bits [2*HALF_W-1:HALF_W] on `dout`. Bit 0 of each half appears on `dout[0]`.
- R4: `dout_oe` rises after the SYNC_STAGES-th clock edge that samples `rd_n` low, and not earlier. It falls after the SYNC_STAGES-th clock edge that samples `rd_n` high again. While `dout_oe` is 0, `dout` is all zeros.
- R5: The half pointer changes one clock edge after `dout_oe` falls. It does not change while the bus is driven.
- R6: When a read of the lower half ends, `word_ready` clears. When a read of the upper half ends, `word_ready` is unchanged.
- R7: When a read of the upper half ends, `half_sel` returns to 0, so the next read presents the lower half again.
- R8: A new word always replaces the stored word, even if the earlier word was never read. A later read returns the new word's halves.
- R9: A write that arrives between the two half reads sets `half_sel` to 0 and `word_ready` to 1. The next read returns the lower half of the new word.
- R10: A write and the end of a read can land on the same edge. In that case the write wins: `half_sel` becomes 0 and `word_ready` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronized inside the block. |
| wr_stb | input | 1 | One-cycle strobe from the receiver: store `wr_word` |
| wr_word | input | 2*HALF_W | Complete received word |
| rd_n | input | 1 | Asynchronous active-low host read strobe |
| dout | output | HALF_W | Half of the stored word selected for the current read; zero when not enabled |
| dout_oe | output | 1 | Bus drive enable, high during a synchronized read |
| word_ready | output | 1 | A stored word is waiting to be read |
| half_sel | output | 1 | Half pointer: 0 selects the lower half, 1 selects the upper half |

## Verification
The bench builds the block with HALF_W = 16 and SYNC_STAGES = 3. The three-stage synchronizer shows that the bus-enable and pointer timing scale with the stage count and are not fixed at two cycles. The 16-bit halves let distinct bit patterns in each half expose any swap or misplaced bit. Stepping the host strobe one clock at a time reaches the exact cycle in which a write and the end of a read meet. It also reaches the window between the two half reads.

// File: rtl/hwrb_pkg.sv
package hwrb_pkg;
  // Which half of the stored word the next host read presents.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  // Number of halves a stored word is split into.
  localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/hwrb_reset_sync.sv
module hwrb_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  // The reset asserts at once and releases through the chain.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/hwrb_strobe_sync.sv
module hwrb_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic strobe_n,
  output logic level_n,
  output logic release_pulse
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = strobe_n;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], strobe_n};
    end
  endgenerate

  assign level_n = chain_q[STAGES-1];
  assign prev_d  = level_n;

  // Idle level of the strobe is high, so reset fills the chain with ones.
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  // The synchronized strobe has just returned high.
  assign release_pulse = level_n & ~prev_q;
endmodule

// File: rtl/hwrb_word_store.sv
module hwrb_word_store
  import hwrb_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = NUM_HALVES * HALF_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  half_e             sel,
  output logic [HALF_W-1:0] half_out
);
  logic [HALF_W-1:0] half_q [NUM_HALVES];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [HALF_W-1:0] half_d;

    // Hold the stored half unless a write is in progress.
    always_comb begin
      half_d = half_q[h];
      if (wr_en) half_d = wr_word[h*HALF_W +: HALF_W];
    end

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) half_q[h] <= '0;
      else         half_q[h] <= half_d;
    end
  end

  always_comb half_out = (sel == HALF_HI) ? half_q[1] : half_q[0];
endmodule

// File: rtl/hwrb_ptr_ctrl.sv
module hwrb_ptr_ctrl
  import hwrb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_sn,
  input  logic  wr_en,
  input  logic  release_pulse,
  output half_e half_ptr,
  output logic  ready
);
  half_e ptr_q, ptr_d;
  logic  rdy_q, rdy_d;

  always_comb begin
    ptr_d = ptr_q;
    rdy_d = rdy_q;
    if (wr_en) begin
      // A write always takes priority over the end of a read.
      ptr_d = HALF_LO;
      rdy_d = 1'b1;
    end else if (release_pulse) begin
      if (ptr_q == HALF_LO) begin
        ptr_d = HALF_HI;
        rdy_d = 1'b0;
      end else begin
        ptr_d = HALF_LO;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ptr_q <= HALF_LO;
      rdy_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      rdy_q <= rdy_d;
    end
  end

  assign half_ptr = ptr_q;
  assign ready    = rdy_q;
endmodule

// File: rtl/half_word_read_buffer.sv
module half_word_read_buffer
  import hwrb_pkg::*;
#(
  parameter int unsigned HALF_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  localparam int unsigned WORD_W     = NUM_HALVES * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_n,
  output logic [HALF_W-1:0] dout,
  output logic              dout_oe,
  output logic              word_ready,
  output logic              half_sel
);
  logic              rst_sn;
  logic              rd_level_n;
  logic              rd_release;
  half_e             ptr;
  logic [HALF_W-1:0] sel_half;

  hwrb_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_sn (rst_sn)
  );

  hwrb_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd (
    .clk           (clk),
    .rst_sn        (rst_sn),
    .strobe_n      (rd_n),
    .level_n       (rd_level_n),
    .release_pulse (rd_release)
  );

  hwrb_word_store #(.HALF_W(HALF_W)) u_store (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .wr_en    (wr_stb),
    .wr_word  (wr_word),
    .sel      (ptr),
    .half_out (sel_half)
  );

  hwrb_ptr_ctrl u_ctrl (
    .clk           (clk),
    .rst_sn        (rst_sn),
    .wr_en         (wr_stb),
    .release_pulse (rd_release),
    .half_ptr      (ptr),
    .ready         (word_ready)
  );

  assign dout_oe  = ~rd_level_n;
  assign dout     = dout_oe ? sel_half : '0;
  assign half_sel = ptr;
endmodule

// File: rtl/half_word_read_buffer_chk.sv
module half_word_read_buffer_chk (
  input logic clk,
  input logic rst_sn,
  input logic wr_stb,
  input logic dout_oe,
  input logic word_ready,
  input logic half_sel
);
  // R2: a write leaves the flag set and the pointer on the lower half
  a_r2_write_arms: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_stb |=> (word_ready && !half_sel));

  // R5: the pointer moves on the edge after the bus is released
  a_r5_ptr_moves_after_release: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr_stb && $fell(dout_oe)) |=> (half_sel != $past(half_sel)));

  // R6: the flag only drops right after a lower-half read ends
  a_r6_ready_drop_source: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(word_ready) |-> (!$past(half_sel) && !$past(dout_oe) && $past(dout_oe, 2)));

  // R6: the end of an upper-half read keeps the flag as it was
  a_r6_upper_keeps_ready: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr_stb && $fell(dout_oe) && half_sel) |=> $stable(word_ready));

  // R7: the end of an upper-half read returns the pointer to the lower half
  a_r7_wraps: assert property (@(posedge clk) disable iff (!rst_sn)
    (!wr_stb && $fell(dout_oe) && half_sel) |=> !half_sel);
endmodule

bind half_word_read_buffer half_word_read_buffer_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .wr_stb     (wr_stb),
  .dout_oe    (dout_oe),
  .word_ready (word_ready),
  .half_sel   (half_sel)
);

// File: tb/half_word_read_buffer_tb_top.sv
`timescale 1ns/1ps
module half_word_read_buffer_tb_top;
  localparam int unsigned HW = 16;
  localparam int unsigned WW = 2 * HW;
  localparam int unsigned SS = 3;
  localparam int unsigned NV = 8;
  localparam logic [WW-1:0] VEC [NV] = '{
    32'h1234_ABCD, 32'hFFFF_0000, 32'h0000_FFFF, 32'h8000_0001,
    32'h5A5A_A5A5, 32'h0001_8000, 32'hDEAD_BEEF, 32'h7FFE_C3C3
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_stb;
  logic [WW-1:0] wr_word;
  logic          rd_n;
  logic [HW-1:0] dout;
  logic          dout_oe;
  logic          word_ready;
  logic          half_sel;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  half_word_read_buffer #(.HALF_W(HW), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_word(wr_word), .rd_n(rd_n),
    .dout(dout), .dout_oe(dout_oe), .word_ready(word_ready), .half_sel(half_sel)
  );

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  task automatic put_word(input logic [WW-1:0] w);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_word = w;
    @(posedge clk);
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  // Full read pulse; returns the value seen while the bus is driven.
  task automatic read_half(output logic [HW-1:0] data, output logic oe);
    @(negedge clk);
    rd_n = 1'b0;
    repeat (SS) @(posedge clk);
    @(negedge clk);
    data = dout;
    oe   = dout_oe;
    rd_n = 1'b1;
    repeat (SS + 1) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #500000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [HW-1:0] d;
    logic          oe;
    rst_n = 1'b0; wr_stb = 1'b0; wr_word = '0; rd_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", word_ready, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 ready", word_ready, 0);
    chk("R1 ptr", half_sel, 0);
    chk("R1 oe", dout_oe, 0);
    read_half(d, oe);
    chk("R1 low half zero", d, 0);
    read_half(d, oe);
    chk("R1 high half zero", d, 0);

    // Table walk: write, then read both halves
    for (int i = 0; i < NV; i++) begin
      put_word(VEC[i]);
      chk("R2 ready after write", word_ready, 1);
      chk("R2 ptr after write", half_sel, 0);
      read_half(d, oe);
      chk("R4 oe during read", oe, 1);
      chk("R3 low half", d, VEC[i][HW-1:0]);
      chk("R4 oe released", dout_oe, 0);
      chk("R4 dout zero when released", dout, 0);
      chk("R6 ready cleared", word_ready, 0);
      chk("R5 ptr advanced", half_sel, 1);
      read_half(d, oe);
      chk("R3 high half", d, VEC[i][WW-1:HW]);
      chk("R6 ready held", word_ready, 0);
      chk("R7 ptr wrapped", half_sel, 0);
    end

    // R4: enable timing edge by edge
    @(negedge clk);
    rd_n = 1'b0;
    repeat (SS - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 oe not early", dout_oe, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 oe on time", dout_oe, 1);
    rd_n = 1'b1;
    repeat (SS - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 oe held", dout_oe, 1);
    chk("R5 ptr steady while driven", half_sel, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 oe dropped", dout_oe, 0);
    chk("R5 ptr not yet moved", half_sel, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R5 ptr moved", half_sel, 1);
    read_half(d, oe);
    chk("R7 wrap after timing read", half_sel, 0);

    // R8: unread word overwritten
    put_word(32'hAAAA_1111);
    put_word(32'hBBBB_2222);
    read_half(d, oe);
    chk("R8 new low half", d, 16'h2222);
    read_half(d, oe);
    chk("R8 new high half", d, 16'hBBBB);

    // R9: write between half reads
    put_word(32'hCCCC_3333);
    read_half(d, oe);
    chk("R9 first half", d, 16'h3333);
    put_word(32'hDDDD_4444);
    chk("R9 ptr reset", half_sel, 0);
    chk("R9 ready set", word_ready, 1);
    read_half(d, oe);
    chk("R9 low half of new word", d, 16'h4444);
    read_half(d, oe);
    chk("R9 high half of new word", d, 16'hDDDD);

    // R10: write on the same edge as the read end
    put_word(32'hEEEE_5555);
    @(negedge clk);
    rd_n = 1'b0;
    repeat (SS) @(posedge clk);
    @(negedge clk);
    chk("R10 low half shown", dout, 16'h5555);
    rd_n = 1'b1;
    repeat (SS) @(posedge clk);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_word = 32'h9999_6666;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
    chk("R10 ptr to low", half_sel, 0);
    chk("R10 ready set", word_ready, 1);
    read_half(d, oe);
    chk("R10 new low half", d, 16'h6666);

    finish_run();
  end
endmodule